// File: doc/BRIEF.md
# Register Rename Status Table

This block tracks, for every architectural register of an out-of-order core, which execution station (if any) will produce the register's next value. Each entry holds a small producer tag. Tag zero means no write is outstanding and the register file already holds the current value. When an instruction issues, the block looks up two source registers. For each one it returns either the register file value or the tag the instruction must wait for. It then records the issuing instruction's station tag as the new producer of the destination register. This overwrites any older tag, so write-after-write ordering needs no stall.

The block also watches the result broadcast bus. A broadcast commits to the register file only when its tag still names a register's latest producer. In that same cycle the register's tag returns to zero. A superseded producer that finishes late therefore leaves the register untouched, and only the last writer in a chain reaches the file. The register file itself sits outside the block: the block drives its two read addresses, takes the read data back combinationally, and drives a single write port.

Top module: `rename_status_table`

## Requirements
- R1: After reset, every register's tag is zero. A lookup of any register returns the register file read data with tag zero.
- R2: A lookup of a register whose tag is nonzero returns that tag and a value of zero, unless R6 applies.
- R3: An allocation sets the destination's tag to the issuing tag from the next cycle on. This holds even when a different nonzero tag was already pending there. An allocation happens when iss_valid=1, iss_dst_en=1 and iss_tag is nonzero.
- R4: A broadcast (cdb_valid=1, nonzero cdb_tag) whose tag equals a register's current tag drives rf_wr_en=1 in the same cycle, with rf_wr_addr set to that register and rf_wr_data equal to cdb_data. From the next cycle that register's tag is zero, and a lookup returns the written data.
- R5: A broadcast whose tag matches no current tag produces no register file write and changes no tag. This covers a producer superseded under R3.
- R6: When a looked-up register's tag equals the tag being broadcast in that cycle, the lookup returns cdb_data with tag zero.
- R7: When one issuing instruction names the same register as a source and as its destination, the source lookup returns the tag held before this allocation.
- R8: An issue with iss_valid=0, with iss_dst_en=0, or with iss_tag=0 changes no tag.
- R9: The bus is ignored when cdb_valid=0 or cdb_tag=0: no write occurs and no tag changes.
- R10: When a matching broadcast and an allocation hit the same register in one cycle, the write of R4 still happens, and the register's tag becomes the newly allocated tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_dst_en | input | 1 | Instruction writes a destination register |
| iss_dst | input | 5 | Destination register index |
| iss_tag | input | 4 | Station tag of the issuing instruction (nonzero) |
| opa_value | output | 64 | First source value (valid when opa_tag is zero) |
| opa_tag | output | 4 | First source producer tag, zero when ready |
| opb_value | output | 64 | Second source value (valid when opb_tag is zero) |
| opb_tag | output | 4 | Second source producer tag, zero when ready |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcasting station |
| cdb_data | input | 64 | Broadcast result value |
| rf_rd_addr_a | output | 5 | Register file read address, first source |
| rf_rd_data_a | input | 64 | Register file read data, first source |
| rf_rd_addr_b | output | 5 | Register file read address, second source |
| rf_rd_data_b | input | 64 | Register file read data, second source |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | 5 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |

## Verification
A stale or lost tag appears on the operand outputs at the very next lookup of that register. A wrongly retained tag reports a nonzero tag where zero is expected. A wrongly cleared tag returns old file data in place of the wait. A tag that fails to match drops the register file write in the same cycle as the broadcast. A match against a superseded tag shows up at once as an rf_wr_en pulse that should not be there. Both errors become visible within one clock of the faulty update, so the directed scenarios read back each touched register in the cycle straight after every allocation or broadcast.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int RRT_NUM_REGS = 32;
  localparam int RRT_DATA_W   = 64;
  localparam int RRT_TAG_W    = 4;
  localparam int RRT_NUM_SRC  = 2;

  // Where a source lookup takes its answer from
  typedef enum logic [1:0] {
    SRC_FILE    = 2'd0,
    SRC_PENDING = 2'd1,
    SRC_BYPASS  = 2'd2
  } rrt_src_kind_e;
endpackage

// File: rtl/rrt_tag_table.sv
module rrt_tag_table #(
  parameter int NUM_REGS = rrt_pkg::RRT_NUM_REGS,
  parameter int TAG_W    = rrt_pkg::RRT_TAG_W,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_en,
  input  logic [AW-1:0]             alloc_idx,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic [NUM_REGS-1:0]       clr_vec,
  output logic [NUM_REGS*TAG_W-1:0] tags_flat
);
  logic [TAG_W-1:0] tag_q [NUM_REGS];
  logic [TAG_W-1:0] tag_d [NUM_REGS];
  logic             tag_en [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    // Next state: allocation takes precedence over a clear in the same cycle
    always_comb begin
      tag_en[r] = 1'b0;
      tag_d[r]  = tag_q[r];
      if (clr_vec[r]) begin
        tag_en[r] = 1'b1;
        tag_d[r]  = '0;
      end
      if (alloc_en && (alloc_idx == AW'(r))) begin
        tag_en[r] = 1'b1;
        tag_d[r]  = alloc_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[r] <= '0;
      end else if (tag_en[r]) begin
        tag_q[r] <= tag_d[r];
      end
    end

    assign tags_flat[r*TAG_W +: TAG_W] = tag_q[r];
  end
endmodule

// File: rtl/rrt_result_match.sv
module rrt_result_match #(
  parameter int NUM_REGS = rrt_pkg::RRT_NUM_REGS,
  parameter int TAG_W    = rrt_pkg::RRT_TAG_W,
  parameter int DATA_W   = rrt_pkg::RRT_DATA_W,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*TAG_W-1:0] tags_flat,
  input  logic                      bus_valid,
  input  logic [TAG_W-1:0]          bus_tag,
  input  logic [DATA_W-1:0]         bus_data,
  output logic [NUM_REGS-1:0]       hit_vec,
  output logic                      wr_en,
  output logic [AW-1:0]             wr_addr,
  output logic [DATA_W-1:0]         wr_data
);
  logic bus_live;
  assign bus_live = bus_valid && (bus_tag != '0);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_cmp
    assign hit_vec[r] = bus_live && (tags_flat[r*TAG_W +: TAG_W] == bus_tag);
  end

  // Lowest matching index wins; at most one match is expected
  always_comb begin
    wr_addr = '0;
    for (int r = NUM_REGS - 1; r >= 0; r--) begin
      if (hit_vec[r]) wr_addr = AW'(r);
    end
  end

  assign wr_en   = |hit_vec;
  assign wr_data = bus_data;
endmodule

// File: rtl/rrt_src_port.sv
module rrt_src_port #(
  parameter int NUM_REGS = rrt_pkg::RRT_NUM_REGS,
  parameter int TAG_W    = rrt_pkg::RRT_TAG_W,
  parameter int DATA_W   = rrt_pkg::RRT_DATA_W,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*TAG_W-1:0] tags_flat,
  input  logic [AW-1:0]             src_idx,
  input  logic [DATA_W-1:0]         file_data,
  input  logic                      bus_valid,
  input  logic [TAG_W-1:0]          bus_tag,
  input  logic [DATA_W-1:0]         bus_data,
  output logic [DATA_W-1:0]         op_value,
  output logic [TAG_W-1:0]          op_tag
);
  import rrt_pkg::*;

  logic [TAG_W-1:0] cur_tag;
  rrt_src_kind_e    kind;

  assign cur_tag = tags_flat[int'(src_idx)*TAG_W +: TAG_W];

  always_comb begin
    if (cur_tag == '0) begin
      kind = SRC_FILE;
    end else if (bus_valid && (bus_tag == cur_tag)) begin
      kind = SRC_BYPASS;
    end else begin
      kind = SRC_PENDING;
    end
  end

  always_comb begin
    case (kind)
      SRC_FILE: begin
        op_value = file_data;
        op_tag   = '0;
      end
      SRC_BYPASS: begin
        op_value = bus_data;
        op_tag   = '0;
      end
      default: begin
        op_value = '0;
        op_tag   = cur_tag;
      end
    endcase
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_REGS = rrt_pkg::RRT_NUM_REGS,
  parameter int TAG_W    = rrt_pkg::RRT_TAG_W,
  parameter int DATA_W   = rrt_pkg::RRT_DATA_W,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int NSRC    = rrt_pkg::RRT_NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [AW-1:0]     iss_src_a,
  input  logic [AW-1:0]     iss_src_b,
  input  logic              iss_dst_en,
  input  logic [AW-1:0]     iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  output logic [DATA_W-1:0] opa_value,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opb_value,
  output logic [TAG_W-1:0]  opb_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [AW-1:0]     rf_rd_addr_a,
  input  logic [DATA_W-1:0] rf_rd_data_a,
  output logic [AW-1:0]     rf_rd_addr_b,
  input  logic [DATA_W-1:0] rf_rd_data_b,
  output logic              rf_wr_en,
  output logic [AW-1:0]     rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_REGS*TAG_W-1:0] tags_flat;
  logic [NUM_REGS-1:0]       hit_vec;
  logic                      alloc_en;

  assign alloc_en = iss_valid && iss_dst_en && (iss_tag != '0);

  rrt_tag_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .alloc_en  (alloc_en),
    .alloc_idx (iss_dst),
    .alloc_tag (iss_tag),
    .clr_vec   (hit_vec),
    .tags_flat (tags_flat)
  );

  rrt_result_match #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
    .tags_flat (tags_flat),
    .bus_valid (cdb_valid),
    .bus_tag   (cdb_tag),
    .bus_data  (cdb_data),
    .hit_vec   (hit_vec),
    .wr_en     (rf_wr_en),
    .wr_addr   (rf_wr_addr),
    .wr_data   (rf_wr_data)
  );

  logic [AW-1:0]     src_idx [NSRC];
  logic [DATA_W-1:0] src_file [NSRC];
  logic [DATA_W-1:0] src_val [NSRC];
  logic [TAG_W-1:0]  src_tag [NSRC];

  assign src_idx[0]  = iss_src_a;
  assign src_idx[1]  = iss_src_b;
  assign src_file[0] = rf_rd_data_a;
  assign src_file[1] = rf_rd_data_b;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rrt_src_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_src (
      .tags_flat (tags_flat),
      .src_idx   (src_idx[s]),
      .file_data (src_file[s]),
      .bus_valid (cdb_valid),
      .bus_tag   (cdb_tag),
      .bus_data  (cdb_data),
      .op_value  (src_val[s]),
      .op_tag    (src_tag[s])
    );
  end

  assign rf_rd_addr_a = iss_src_a;
  assign rf_rd_addr_b = iss_src_b;
  assign opa_value    = src_val[0];
  assign opa_tag      = src_tag[0];
  assign opb_value    = src_val[1];
  assign opb_tag      = src_tag[1];
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_dst_en,
  input logic [AW-1:0]     iss_dst,
  input logic [TAG_W-1:0]  iss_tag,
  input logic [DATA_W-1:0] opa_value,
  input logic [TAG_W-1:0]  opa_tag,
  input logic [TAG_W-1:0]  opb_tag,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic              rf_wr_en,
  input logic [AW-1:0]     rf_wr_addr,
  input logic [NUM_REGS-1:0] hit_vec
);
  // R2
  pending_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_tag != '0) |-> (opa_value == '0));

  // R3
  latest_alloc_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_dst_en && (iss_tag != '0)) && rf_wr_en &&
     (rf_wr_addr == $past(iss_dst))) |-> (cdb_tag == $past(iss_tag)));

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  no_wait_on_live_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (opb_tag != '0)) |-> (opb_tag != cdb_tag));

  // R9
  idle_bus_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cdb_valid || (cdb_tag == '0)) |-> !rf_wr_en);
endmodule

bind rename_status_table rrt_checker #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rrt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_dst_en (iss_dst_en),
  .iss_dst    (iss_dst),
  .iss_tag    (iss_tag),
  .opa_value  (opa_value),
  .opa_tag    (opa_tag),
  .opb_tag    (opb_tag),
  .cdb_valid  (cdb_valid),
  .cdb_tag    (cdb_tag),
  .rf_wr_en   (rf_wr_en),
  .rf_wr_addr (rf_wr_addr),
  .hit_vec    (hit_vec)
);

// File: tb/sim_rename_status_table.sv
`timescale 1ns/1ps
module sim_rename_status_table;
  localparam int NR = 32;
  localparam int TW = 4;
  localparam int DW = 64;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [AW-1:0] iss_src_a = '0;
  logic [AW-1:0] iss_src_b = '0;
  logic          iss_dst_en = 1'b0;
  logic [AW-1:0] iss_dst = '0;
  logic [TW-1:0] iss_tag = '0;
  logic [DW-1:0] opa_value, opb_value;
  logic [TW-1:0] opa_tag, opb_tag;
  logic          cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic [AW-1:0] rf_rd_addr_a, rf_rd_addr_b, rf_wr_addr;
  logic [DW-1:0] rf_rd_data_a, rf_rd_data_b, rf_wr_data;
  logic          rf_wr_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  // Register file model outside the block
  logic [DW-1:0] rf [NR];
  initial begin
    for (int i = 0; i < NR; i++) rf[i] = 64'hA5A5_0000_0000_0000 | 64'(i);
  end
  always @(posedge clk) if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;
  assign rf_rd_data_a = rf[rf_rd_addr_a];
  assign rf_rd_data_b = rf[rf_rd_addr_b];

  rename_status_table u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .opa_value(opa_value), .opa_tag(opa_tag), .opb_value(opb_value), .opb_tag(opb_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .rf_rd_addr_a(rf_rd_addr_a), .rf_rd_data_a(rf_rd_data_a),
    .rf_rd_addr_b(rf_rd_addr_b), .rf_rd_data_b(rf_rd_data_b),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
  );

  function automatic logic [DW-1:0] init_val(int i);
    return 64'hA5A5_0000_0000_0000 | 64'(i);
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Inputs change just after the falling edge; checks sit 5 ns later
  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0; iss_dst_en = 1'b0; iss_tag = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic look(string req, int a, logic [DW-1:0] va, logic [TW-1:0] ta);
    iss_src_a = AW'(a);
    settle();
    chk(req, "opa_value", opa_value, va);
    chk(req, "opa_tag", DW'(opa_tag), DW'(ta));
  endtask

  task automatic alloc(int dst, int tag);
    iss_valid = 1'b1; iss_dst_en = 1'b1; iss_dst = AW'(dst); iss_tag = TW'(tag);
  endtask

  task automatic bcast(int tag, logic [DW-1:0] d);
    cdb_valid = 1'b1; cdb_tag = TW'(tag); cdb_data = d;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NR; i++) begin
      iss_src_a = AW'(i); iss_src_b = AW'(NR - 1 - i);
      settle();
      chk("R1", "opa_value", opa_value, init_val(i));
      chk("R1", "opa_tag", DW'(opa_tag), '0);
      chk("R1", "opb_value", opb_value, init_val(NR - 1 - i));
      chk("R1", "opb_tag", DW'(opb_tag), '0);
      next_cycle();
    end
  endtask

  task automatic t_alloc_basic();
    alloc(5, 3);
    next_cycle();
    look("R2", 5, '0, 4'd3);
    next_cycle();
  endtask

  task automatic t_waw();
    alloc(7, 1);
    next_cycle();
    alloc(7, 2);
    next_cycle();
    look("R3", 7, '0, 4'd2);
    bcast(1, 64'h1111);
    settle();
    chk("R5", "rf_wr_en stale tag", DW'(rf_wr_en), '0);
    next_cycle();
    look("R5", 7, '0, 4'd2);
    bcast(2, 64'h2222_3333);
    settle();
    chk("R4", "rf_wr_en", DW'(rf_wr_en), 1);
    chk("R4", "rf_wr_addr", DW'(rf_wr_addr), 7);
    chk("R4", "rf_wr_data", rf_wr_data, 64'h2222_3333);
    next_cycle();
    look("R4", 7, 64'h2222_3333, 4'd0);
    next_cycle();
  endtask

  task automatic t_bypass();
    alloc(9, 4);
    next_cycle();
    iss_src_b = AW'(9);
    bcast(4, 64'hBEEF);
    settle();
    chk("R6", "opb_value", opb_value, 64'hBEEF);
    chk("R6", "opb_tag", DW'(opb_tag), '0);
    next_cycle();
    look("R6", 9, 64'hBEEF, 4'd0);
    next_cycle();
  endtask

  task automatic t_same_rw();
    alloc(10, 5);
    next_cycle();
    alloc(10, 6);
    look("R7", 10, '0, 4'd5);
    next_cycle();
    look("R7", 10, '0, 4'd6);
    alloc(11, 7);
    look("R7", 11, init_val(11), 4'd0);
    next_cycle();
    look("R7", 11, '0, 4'd7);
    next_cycle();
  endtask

  task automatic t_noalloc();
    iss_valid = 1'b0; iss_dst_en = 1'b1; iss_dst = AW'(12); iss_tag = 4'd8;
    next_cycle();
    look("R8", 12, init_val(12), 4'd0);
    iss_valid = 1'b1; iss_dst_en = 1'b0; iss_dst = AW'(12); iss_tag = 4'd8;
    next_cycle();
    look("R8", 12, init_val(12), 4'd0);
    alloc(12, 0);
    next_cycle();
    look("R8", 12, init_val(12), 4'd0);
    next_cycle();
  endtask

  task automatic t_ignore_bus();
    alloc(13, 9);
    next_cycle();
    cdb_valid = 1'b0; cdb_tag = 4'd9; cdb_data = 64'hDEAD;
    settle();
    chk("R9", "rf_wr_en idle", DW'(rf_wr_en), '0);
    next_cycle();
    look("R9", 13, '0, 4'd9);
    bcast(0, 64'hDEAD);
    settle();
    chk("R9", "rf_wr_en tag0", DW'(rf_wr_en), '0);
    next_cycle();
    look("R9", 13, '0, 4'd9);
    next_cycle();
  endtask

  task automatic t_collide();
    alloc(14, 10);
    next_cycle();
    bcast(10, 64'hC0FFEE);
    alloc(14, 11);
    settle();
    chk("R10", "rf_wr_en", DW'(rf_wr_en), 1);
    chk("R10", "rf_wr_addr", DW'(rf_wr_addr), 14);
    next_cycle();
    look("R10", 14, '0, 4'd11);
    bcast(11, 64'hFACE);
    next_cycle();
    look("R10", 14, 64'hFACE, 4'd0);
    next_cycle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_alloc_basic();
    t_waw();
    t_bypass();
    t_same_rw();
    t_noalloc();
    t_ignore_bus();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule